// File: doc/BRIEF.md
# Shift-Subtract Modular Multiplier with Precomputed Doubling

This block computes p = a · b mod m for an odd W-bit modulus m and operands a, b already reduced below m. It works bit-serially: the multiplier b is consumed from its least significant bit upward. A running multiple u, equal to a · 2^i mod m, is added into a partial result p whenever the current bit of b is one. Both p and u are kept below m by at most one conditional subtraction of m per step.

The doubling of u is the slow part of a plain shift-subtract design. Here the two possible values of the next 2u − m are formed one step early and held in registers. A single multiplexer then picks between them, and the sign of the picked value chooses the next u. A caller pulses `start` for one cycle with the operands on the inputs. It waits for `ready`, then reads `result`.

Top module: `modmul_shiftsub`

## Requirements
- R1: When `ready` rises, `result` equals (a · b) mod m for the a, b, m sampled with the accepted start, for any odd m and a, b < m, including a = m−1 and b = m−1.
- R2: `ready` rises exactly W+1 clock edges after the edge that accepts `start`. Counting the start cycle as cycle 1, it is high in cycle W+2, which is 258 cycles for W = 256.
- R3: `busy` is high from the cycle after an accepted start until `ready` rises. `busy` and `ready` are never high together.
- R4: After completion, `ready` stays high and `result` holds its value until the next accepted start. That start clears `ready` at the next edge.
- R5: A `start` pulse while `busy` is high is ignored: the running result and its completion cycle are unchanged.
- R6: A zero operand (a = 0 or b = 0) yields a result of 0.
- R7: After every step the partial result stays in [0, m), and so does the running multiple.
- R8: In every step, the candidate taken from the two precomputed registers equals 2u − m for the current running multiple u.
- R9: While reset is asserted, `ready` and `busy` are low and `result` is 0.
- R10: The operands are captured at the accepted start. Changes on `op_a`, `op_b` or `modulus` while `busy` is high do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only when not busy |
| op_a | input | W | Multiplicand, below modulus |
| op_b | input | W | Multiplier, below modulus |
| modulus | input | W | Odd modulus |
| result | output | W | Product modulo modulus, valid while ready |
| ready | output | 1 | Result valid; held until next accepted start |
| busy | output | 1 | Multiplication in progress |

## Verification
Random full-width operand sets with an odd modulus exercise both outcomes of each conditional subtraction on most steps. Operands equal to m−1 with an all-ones modulus force the subtraction branch nearly every step. Zero operands show that a zero multiplier bit leaves the accumulator untouched, and b = 1 shows that only the first running multiple is used. Tiny moduli (1 and 3) expose wrap-around errors in the precomputed candidates, where 4u − 3m goes far negative. Two further runs, one with an extra start pulse and one with operand changes during the run, separate operand capture from live use of the inputs.

// File: rtl/modmul_pkg.sv
package modmul_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } mm_phase_e;
endpackage

// File: rtl/modmul_seq.sv
module modmul_seq
  import modmul_pkg::*;
#(
  parameter int W = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic ready
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mm_phase_e   ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        rdy_q, rdy_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    load  = 1'b0;
    step  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          load  = 1'b1;
          ph_d  = PH_RUN;
          cnt_d = '0;
          rdy_d = 1'b0;
        end
      end
      PH_RUN: begin
        step = 1'b1;
        if (cnt_q == LAST) ph_d = PH_FIN;
        else               cnt_d = cnt_q + 1'b1;
      end
      PH_FIN: begin
        ph_d  = PH_IDLE;
        rdy_d = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign busy  = (ph_q != PH_IDLE);
  assign ready = rdy_q;

  assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !ready));
  assert_ready_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(busy));
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ph_q == PH_RUN && cnt_q != LAST) |=> (ph_q == PH_RUN && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/modmul_acc.sv
module modmul_acc #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] u,
  input  logic [W-1:0] m,
  output logic [W-1:0] p
);
  localparam int AW = W + 2;

  logic [W-1:0]  p_q, p_d;
  logic [AW-1:0] sum_w, red_w;

  always_comb begin
    sum_w = {2'b00, p_q} + {2'b00, u};
    red_w = sum_w - {2'b00, m};
    p_d   = p_q;
    if (clr)     p_d = '0;
    else if (en) p_d = red_w[AW-1] ? sum_w[W-1:0] : red_w[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_q <= '0;
    else        p_q <= p_d;
  end

  assign p = p_q;

  assert_p_reduced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (p_q < m));
  assert_zero_bit_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(p_q));
endmodule

// File: rtl/modmul_dbl.sv
module modmul_dbl #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] m_in,
  input  logic [W-1:0] m,
  output logic [W-1:0] u
);
  localparam int EW = W + 3;

  logic [W-1:0]  u_q, u_d;
  logic [EW-1:0] x_q, x_d, y_q, y_d;
  logic          sel_q, sel_d;
  logic [EW-1:0] u_x, m_x, cand, quad_u;
  logic          cand_neg;

  always_comb begin
    u_x      = {3'b000, u_q};
    m_x      = {3'b000, m};
    quad_u   = {u_q, 2'b00} ;
    cand     = sel_q ? y_q : x_q;
    cand_neg = cand[EW-1];
    u_d   = u_q;
    x_d   = x_q;
    y_d   = y_q;
    sel_d = sel_q;
    if (load) begin
      u_d   = a_in;
      x_d   = {2'b00, a_in, 1'b0} - {3'b000, m_in};
      y_d   = {2'b00, a_in, 1'b0} - {3'b000, m_in};
      sel_d = 1'b0;
    end else if (step) begin
      u_d   = cand_neg ? {u_q[W-2:0], 1'b0} : cand[W-1:0];
      x_d   = quad_u - m_x;
      y_d   = quad_u - m_x - {m_x[EW-2:0], 1'b0};
      sel_d = ~cand_neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q   <= '0;
      x_q   <= '0;
      y_q   <= '0;
      sel_q <= 1'b0;
    end else begin
      u_q   <= u_d;
      x_q   <= x_d;
      y_q   <= y_d;
      sel_q <= sel_d;
    end
  end

  assign u = u_q;

  assert_precompute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cand == ({u_x[EW-2:0], 1'b0} - m_x)));
  assert_u_reduced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (u_q < m));
endmodule

// File: rtl/modmul_shiftsub.sv
module modmul_shiftsub #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] result,
  output logic         ready,
  output logic         busy
);
  logic         load, step;
  logic [W-1:0] b_q, b_d, m_q, m_d, u_w;

  modmul_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .busy(busy), .ready(ready)
  );

  always_comb begin
    b_d = b_q;
    m_d = m_q;
    if (load) begin
      b_d = op_b;
      m_d = modulus;
    end else if (step) begin
      b_d = {1'b0, b_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      m_q <= '0;
    end else begin
      b_q <= b_d;
      m_q <= m_d;
    end
  end

  modmul_dbl #(.W(W)) u_dbl (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .a_in(op_a), .m_in(modulus), .m(m_q), .u(u_w)
  );

  modmul_acc #(.W(W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(step & b_q[0]),
    .u(u_w), .m(m_q), .p(result)
  );

  assert_operands_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && $past(busy)) |-> $stable(m_q));
endmodule

// File: tb/tb_modmul_shiftsub.sv
module tb_modmul_shiftsub;
  localparam int W = 256;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, modulus = '0;
  logic [W-1:0] result;
  logic         ready, busy;

  modmul_shiftsub #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .modulus(modulus), .result(result), .ready(ready), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [W-1:0] exp;
    int           t0;
  } sb_item_t;

  sb_item_t     sbq[$];
  int           checks = 0, fails = 0, cyc = 0;
  logic         rdy_prev = 1'b0;
  logic [W-1:0] last_exp = '0;
  logic         done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_mod(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] m);
    logic [2*W-1:0] prod, mm;
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    mm   = {{W{1'b0}}, m};
    return W'(prod % mm);
  endfunction

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] r;
    for (int i = 0; i < W/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // Monitor: pops the scoreboard on each rising ready (R1, R2)
  always @(negedge clk) begin
    if (rst_n && ready && !rdy_prev) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R1 unexpected ready", result, '0);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        chk(result == it.exp, "R1 result", result, it.exp);
        chk((cyc - it.t0) == W + 2, "R2 latency", W'(cyc - it.t0), W'(W + 2));
        last_exp = it.exp;
      end
    end
    rdy_prev = ready;
  end

  // mode 0 plain, 1 extra start pulse while busy (R5), 2 operand change while busy (R10)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] m, input int mode);
    sb_item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    op_a = a; op_b = b; modulus = m; start = 1'b1;
    it.exp = ref_mod(a, b, m);
    it.t0  = cyc;
    sbq.push_back(it);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !ready, "R3 busy after start", W'({busy, ready}), W'(2'b10));
    repeat (5) @(negedge clk);
    if (mode == 1) begin
      op_a = rnd(); op_b = rnd(); modulus = rnd() | 1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end else if (mode == 2) begin
      op_a = rnd(); op_b = rnd(); modulus = rnd() | 1;
    end
    while (!ready) begin
      if (busy && ready) chk(1'b0, "R3 exclusive", '0, '0);
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] m, a, b, ones;
    ones = '1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(ready == 1'b0, "R9 ready in reset", W'(ready), '0);
    chk(busy == 1'b0, "R9 busy in reset", W'(busy), '0);
    chk(result == '0, "R9 result in reset", result, '0);
    rst_n = 1'b1;

    // R1 extreme operands: all-ones modulus, m-1 squared
    run_op(ones - 1, ones - 1, ones, 0);
    // R6 zero operands
    m = rnd() | 1;
    run_op('0, rnd() % m, m, 0);
    run_op(rnd() % m, '0, m, 0);
    // R1 b = 1
    run_op(rnd() % m, W'(1), m, 0);
    // R1 tiny moduli
    run_op(W'(2), W'(2), W'(3), 0);
    run_op('0, '0, W'(1), 0);
    // R1 random full-width operands
    for (int k = 0; k < 12; k++) begin
      m = rnd() | 1;
      if (k % 2 == 0) m[W-1] = 1'b1;
      a = rnd() % m;
      b = rnd() % m;
      run_op(a, b, m, 0);
    end
    // R4 hold after completion
    repeat (6) @(negedge clk);
    chk(ready == 1'b1, "R4 ready held", W'(ready), W'(1));
    chk(result == last_exp, "R4 result held", result, last_exp);
    // R5 start while busy ignored
    m = rnd() | 1;
    run_op(rnd() % m, rnd() % m, m, 1);
    // R10 operand changes while busy
    m = rnd() | 1;
    run_op(ones - 1 - (rnd() % 5), rnd() % m, m | ones, 2);
    run_op(rnd() % m, rnd() % m, m, 2);
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R1 scoreboard drained", W'(sbq.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule